// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This peripheral carries short fixed-length messages from a local processor to a remote one. It has a parameterised number of independent channels. Each channel occupies a 64-byte window on a plain 32-bit register bus. A window holds an owner mask, a target mask, a mode/status word, an interrupt mask, two clear strobes, a send strobe and a block of message words. All channel writes pass through a single global key-protected lock.

Each channel moves through four states: free, owned, in flight and acknowledged. Software claims a free channel by writing its one-hot owner bit. It then fills the message, selects a target interrupt vector and triggers the send with its owner bit. The block raises the target interrupt as soon as the send is accepted. In automatic mode it marks the channel acknowledged on the following cycle and raises the owner's interrupt. The owner clears that interrupt to make the channel usable again. In manual mode the acknowledge comes when the receiver clears its target interrupt. Interrupt vectors from all channels are OR-merged onto two 32-bit outputs.

Reads return data one cycle after the request. Accesses are word aligned. An unaligned offset matches no register.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset the lock is engaged and reads 1. Every channel's mode word reads 0x10 (free). Every interrupt mask reads 0xFFFFFFFF. Both interrupt outputs are zero.
- R2: Writing 0x1ACCE551 to the lock register at 0xA00 disengages the lock, and the register then reads 0. Writing any other value engages it again, and it then reads 1.
- R3: While the lock is engaged, writes to any channel register leave that channel's registers and interrupt outputs unchanged.
- R4: Writing a non-zero value to the owner register (offset 0x00) of a free channel stores that value and sets mode bit 5 (owned). An owner write to a channel that is not free is ignored.
- R5: Writing the send register (offset 0x1C) of an owned channel with a value that shares a bit with the owner mask starts a send. The target mask (0x04) gated by the inverted interrupt mask (0x14) then appears on irq_dst on the next cycle. A send value with no common bit is ignored.
- R6: With mode bit 0 set (automatic, offset 0x10), the channel reaches the acknowledged state one cycle after the send. Mode bit 7 is then set and the owner mask appears on irq_src.
- R7: Writing the interrupt-clear register (0x18) of an acknowledged channel with an owner bit returns it to owned (mode bit 5) and removes its bits from irq_src.
- R8: Target status (0x0C) reads the target mask while a target interrupt is pending and 0 otherwise. Writing the target-clear register (0x08) with a target bit ends the pending interrupt. In manual mode that write also moves an in-flight channel to acknowledged.
- R9: Message word i (i = 0..7) is written and read at offset 0x20 + 4i of its channel.
- R10: Writing zero to the owner register of an owned channel releases it. Mode bit 4 (free) is then set and the owner mask reads 0.
- R11: Read data appears on bus_rdata one cycle after the read request. Addresses outside the channel windows and the lock register read 0.
- R12: Each bit of irq_dst and irq_src is the OR of that bit over all channels, so two channels sharing a vector keep it high while either of them drives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_dst | output | 32 | Merged target interrupt vectors |
| irq_src | output | 32 | Merged owner (acknowledge) interrupt vectors |

## Verification
The automatic acknowledge step of one channel needs no bus access. It can therefore land on the same edge as a bus write that clears another channel's acknowledge. When both channels own the same interrupt vector, one drives the vector up while the other drives it down. The bench provokes this by sending on one channel and, in the very next cycle, clearing a second channel that shares its owner bit. The merged irq_src bit must stay high. A behavioural model that tracks each channel separately is compared against both interrupt outputs and every read on every clock, including through a long mixed random run on four channels that share vectors.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      CH_FREE  = 2'd0,
      CH_OWNED = 2'd1,
      CH_FLY   = 2'd2,
      CH_ACKED = 2'd3
   } ch_state_e;

   localparam int WIN_BITS = 6;

   localparam logic [5:0] OFF_OWNER  = 6'h00;
   localparam logic [5:0] OFF_TARGET = 6'h04;
   localparam logic [5:0] OFF_TCLR   = 6'h08;
   localparam logic [5:0] OFF_TSTAT  = 6'h0C;
   localparam logic [5:0] OFF_MODE   = 6'h10;
   localparam logic [5:0] OFF_IMASK  = 6'h14;
   localparam logic [5:0] OFF_ACLR   = 6'h18;
   localparam logic [5:0] OFF_SEND   = 6'h1C;

   localparam int MODE_AUTO_BIT  = 0;
   localparam int MODE_FREE_BIT  = 4;
   localparam int MODE_OWNED_BIT = 5;
   localparam int MODE_ACKED_BIT = 7;

   localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/mbx_lock.sv
module mbx_lock #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              locked
);
   import mbx_pkg::*;

   logic key_ok;
   assign key_ok = (wr_data == DATA_W'(UNLOCK_KEY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (wr_en) begin
         locked <= !key_ok;
      end
   end

   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && key_ok) |=> !locked);
   assert_bad_key_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !key_ok) |=> locked);
   assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(locked));

endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [5:0]        wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [5:0]        rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] irq_dst,
   output logic [DATA_W-1:0] irq_src
);
   import mbx_pkg::*;

   ch_state_e         state_q;
   logic [DATA_W-1:0] owner_q;
   logic [DATA_W-1:0] target_q;
   logic [DATA_W-1:0] imask_q;
   logic              auto_q;
   logic              pend_q;
   logic [DATA_W-1:0] msg_q [MSG_WORDS];

   logic owner_hit;
   logic target_hit;
   assign owner_hit  = (wr_data & owner_q) != '0;
   assign target_hit = (wr_data & target_q) != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CH_FREE;
         owner_q  <= '0;
         target_q <= '0;
         imask_q  <= '1;
         auto_q   <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (state_q == CH_FLY && auto_q) begin
            state_q <= CH_ACKED;
         end
         if (wr_en) begin
            case (wr_off)
               OFF_OWNER: begin
                  if (state_q == CH_FREE && wr_data != '0) begin
                     owner_q <= wr_data;
                     state_q <= CH_OWNED;
                  end else if (state_q == CH_OWNED && wr_data == '0) begin
                     owner_q <= '0;
                     state_q <= CH_FREE;
                  end
               end
               OFF_TARGET: target_q <= wr_data;
               OFF_TCLR: begin
                  if (target_hit) begin
                     pend_q <= 1'b0;
                     if (state_q == CH_FLY && !auto_q) begin
                        state_q <= CH_ACKED;
                     end
                  end
               end
               OFF_MODE:  auto_q  <= wr_data[MODE_AUTO_BIT];
               OFF_IMASK: imask_q <= wr_data;
               OFF_ACLR: begin
                  if (state_q == CH_ACKED && owner_hit) begin
                     state_q <= CH_OWNED;
                  end
               end
               OFF_SEND: begin
                  if (state_q == CH_OWNED && owner_hit) begin
                     state_q <= CH_FLY;
                     pend_q  <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < MSG_WORDS; w++) begin
            msg_q[w] <= '0;
         end
      end else if (wr_en && wr_off[5] && wr_off[1:0] == 2'b00) begin
         for (int w = 0; w < MSG_WORDS; w++) begin
            if (wr_off[4:2] == 3'(w)) begin
               msg_q[w] <= wr_data;
            end
         end
      end
   end

   logic [DATA_W-1:0] mode_rd;
   logic [DATA_W-1:0] msg_rd;

   always_comb begin
      mode_rd                 = '0;
      mode_rd[MODE_AUTO_BIT]  = auto_q;
      mode_rd[MODE_FREE_BIT]  = (state_q == CH_FREE);
      mode_rd[MODE_OWNED_BIT] = (state_q == CH_OWNED);
      mode_rd[MODE_ACKED_BIT] = (state_q == CH_ACKED);
   end

   always_comb begin
      msg_rd = '0;
      if (rd_off[5] && rd_off[1:0] == 2'b00) begin
         for (int w = 0; w < MSG_WORDS; w++) begin
            if (rd_off[4:2] == 3'(w)) begin
               msg_rd = msg_q[w];
            end
         end
      end
   end

   always_comb begin
      case (rd_off)
         OFF_OWNER:  rd_data = owner_q;
         OFF_TARGET: rd_data = target_q;
         OFF_TSTAT:  rd_data = pend_q ? target_q : '0;
         OFF_MODE:   rd_data = mode_rd;
         OFF_IMASK:  rd_data = imask_q;
         default:    rd_data = msg_rd;
      endcase
   end

   assign irq_dst = pend_q ? (target_q & ~imask_q) : '0;
   assign irq_src = (state_q == CH_ACKED) ? owner_q : '0;

   assert_auto_ack_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_FLY && auto_q) |=> (state_q == CH_ACKED && irq_src != '0));
   assert_fly_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_FLY) |-> pend_q);
   assert_free_unowned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_FREE) |-> (owner_q == '0));
   assert_owned_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CH_FREE) |-> (owner_q != '0));
   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_ACKED && wr_en && wr_off == OFF_ACLR && owner_hit)
      |=> (state_q == CH_OWNED && irq_src == '0));
   assert_no_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && state_q != CH_FLY) |=> ($stable(owner_q) && $stable(target_q) && $stable(imask_q)));

endmodule

// File: rtl/mbx_irq_or.sv
module mbx_irq_or #(
   parameter int NCH = 32,
   parameter int W   = 32
) (
   input  logic [NCH*W-1:0] vec_in,
   output logic [W-1:0]     vec_out
);
   always_comb begin
      vec_out = '0;
      for (int c = 0; c < NCH; c++) begin
         vec_out = vec_out | vec_in[c*W +: W];
      end
   end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
   parameter int NCH       = 32,
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 8,
   parameter int ADDR_W    = 12,
   parameter int LOCK_ADDR = 'hA00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] irq_dst,
   output logic [DATA_W-1:0] irq_src
);
   import mbx_pkg::*;

   localparam int IDX_W = ADDR_W - WIN_BITS;

   if (NCH < 1 || NCH * (1 << WIN_BITS) > LOCK_ADDR) begin : g_bad_map
      $error("mbx_ctrl: channel windows overlap the lock register");
   end
   if ((1 << ADDR_W) <= LOCK_ADDR) begin : g_bad_addr
      $error("mbx_ctrl: ADDR_W too small for LOCK_ADDR");
   end
   if (DATA_W < 32) begin : g_bad_width
      $error("mbx_ctrl: DATA_W must hold the unlock key");
   end
   if (MSG_WORDS < 1 || MSG_WORDS > 8) begin : g_bad_msg
      $error("mbx_ctrl: MSG_WORDS must fit the 32-byte data area");
   end

   logic [IDX_W-1:0] ch_idx;
   logic             hit_lock;
   logic             hit_chan;
   logic             locked;
   logic             wr_cyc;

   assign ch_idx   = bus_addr[ADDR_W-1:WIN_BITS];
   assign hit_lock = (bus_addr == ADDR_W'(LOCK_ADDR));
   assign hit_chan = (int'(ch_idx) < NCH);
   assign wr_cyc   = bus_req && bus_we;

   mbx_lock #(.DATA_W(DATA_W)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_cyc && hit_lock),
      .wr_data (bus_wdata),
      .locked  (locked)
   );

   logic [NCH-1:0]        chan_we;
   logic [DATA_W-1:0]     chan_rd [NCH];
   logic [NCH*DATA_W-1:0] dst_all;
   logic [NCH*DATA_W-1:0] src_all;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      assign chan_we[g] = wr_cyc && !locked && hit_chan && (ch_idx == IDX_W'(g));

      mbx_chan #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (chan_we[g]),
         .wr_off  (bus_addr[WIN_BITS-1:0]),
         .wr_data (bus_wdata),
         .rd_off  (bus_addr[WIN_BITS-1:0]),
         .rd_data (chan_rd[g]),
         .irq_dst (dst_all[g*DATA_W +: DATA_W]),
         .irq_src (src_all[g*DATA_W +: DATA_W])
      );
   end

   mbx_irq_or #(.NCH(NCH), .W(DATA_W)) u_or_dst (.vec_in(dst_all), .vec_out(irq_dst));
   mbx_irq_or #(.NCH(NCH), .W(DATA_W)) u_or_src (.vec_in(src_all), .vec_out(irq_src));

   logic [DATA_W-1:0] sel_rd;
   always_comb begin
      sel_rd = '0;
      if (hit_lock) begin
         sel_rd = DATA_W'(locked);
      end else if (hit_chan) begin
         for (int c = 0; c < NCH; c++) begin
            if (ch_idx == IDX_W'(c)) begin
               sel_rd = chan_rd[c];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_req && !bus_we) begin
         bus_rdata <= sel_rd;
      end
   end

   assert_chan_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_we));
   assert_locked_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && hit_chan && locked) |-> (chan_we == '0));
   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> $stable(bus_rdata));

endmodule

// File: tb/mbx_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_ctrl_bench;
   localparam int NCH = 32;
   localparam logic [11:0] LOCK = 12'hA00;
   localparam logic [31:0] KEY  = 32'h1ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, irq_dst, irq_src;

   always #2.5 clk = ~clk;

   mbx_ctrl u_mbx_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_dst(irq_dst), .irq_src(irq_src)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model: 0 free, 1 owned, 2 in flight, 3 acked
   int          m_st [NCH];
   int          old_st [NCH];
   bit          old_auto [NCH];
   logic [31:0] m_src [NCH];
   logic [31:0] m_dst [NCH];
   logic [31:0] m_imask [NCH];
   logic [31:0] m_data [NCH][8];
   bit          m_auto [NCH];
   bit          m_dp [NCH];
   bit          m_lock;
   logic [31:0] m_rd;
   bit          m_rdv;

   function automatic logic [11:0] ca(int c, int o);
      return 12'(c * 64 + o);
   endfunction

   function automatic logic [31:0] mread(logic [11:0] a);
      int c;
      int o;
      logic [31:0] v;
      if (a == LOCK) return {31'b0, m_lock};
      if (int'(a) >= NCH * 64) return 32'h0;
      c = int'(a[11:6]);
      o = int'(a[5:0]);
      case (o)
         'h00: return m_src[c];
         'h04: return m_dst[c];
         'h0C: return m_dp[c] ? m_dst[c] : 32'h0;
         'h10: begin
            v = '0;
            v[0] = m_auto[c];
            v[4] = (m_st[c] == 0);
            v[5] = (m_st[c] == 1);
            v[7] = (m_st[c] == 3);
            return v;
         end
         'h14: return m_imask[c];
         default: begin
            if (o >= 'h20 && (o % 4) == 0) return m_data[c][(o - 'h20) / 4];
            return 32'h0;
         end
      endcase
   endfunction

   task automatic mwrite(logic [11:0] a, logic [31:0] d);
      int c;
      int o;
      if (a == LOCK) begin
         m_lock = (d != KEY);
         return;
      end
      if (m_lock || int'(a) >= NCH * 64) return;
      c = int'(a[11:6]);
      o = int'(a[5:0]);
      case (o)
         'h00: begin
            if (old_st[c] == 0 && d != 0) begin m_src[c] = d; m_st[c] = 1; end
            else if (old_st[c] == 1 && d == 0) begin m_src[c] = 0; m_st[c] = 0; end
         end
         'h04: m_dst[c] = d;
         'h08: if ((d & m_dst[c]) != 0) begin
            m_dp[c] = 1'b0;
            if (old_st[c] == 2 && !old_auto[c]) m_st[c] = 3;
         end
         'h10: m_auto[c] = d[0];
         'h14: m_imask[c] = d;
         'h18: if (old_st[c] == 3 && (d & m_src[c]) != 0) m_st[c] = 1;
         'h1C: if (old_st[c] == 1 && (d & m_src[c]) != 0) begin m_st[c] = 2; m_dp[c] = 1'b1; end
         default: if (o >= 'h20 && (o % 4) == 0) m_data[c][(o - 'h20) / 4] = d;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lock = 1'b1;
         m_rdv  = 1'b0;
         m_rd   = '0;
         for (int c = 0; c < NCH; c++) begin
            m_st[c] = 0; m_src[c] = 0; m_dst[c] = 0; m_imask[c] = '1;
            m_auto[c] = 0; m_dp[c] = 0;
            for (int w = 0; w < 8; w++) m_data[c][w] = 0;
         end
      end else begin
         m_rdv = bus_req && !bus_we;
         if (m_rdv) m_rd = mread(bus_addr);
         for (int c = 0; c < NCH; c++) begin
            old_st[c] = m_st[c];
            old_auto[c] = m_auto[c];
            if (old_st[c] == 2 && old_auto[c]) m_st[c] = 3;
         end
         if (bus_req && bus_we) mwrite(bus_addr, bus_wdata);
      end
   end

   always @(negedge clk) begin
      logic [31:0] ed;
      logic [31:0] es;
      if (rst_n && !done) begin
         ed = '0;
         es = '0;
         for (int c = 0; c < NCH; c++) begin
            if (m_dp[c]) ed = ed | (m_dst[c] & ~m_imask[c]);
            if (m_st[c] == 3) es = es | m_src[c];
         end
         chk("R12 model irq_dst", irq_dst, ed);
         chk("R12 model irq_src", irq_src, es);
         if (m_rdv) chk("R11 model rdata", bus_rdata, m_rd);
      end
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq_dst", irq_dst, 32'h0);
      chk("R1 irq_src", irq_src, 32'h0);
      rd(LOCK, 32'h1, "R1 lock");
      rd(ca(0, 'h10), 32'h10, "R1 mode");
      rd(ca(5, 'h14), 32'hFFFF_FFFF, "R1 imask");

      // R3 locked writes ignored
      wr(ca(0, 'h00), 32'h1);
      rd(ca(0, 'h10), 32'h10, "R3 mode");
      rd(ca(0, 'h00), 32'h0, "R3 owner");

      // R2 unlock
      wr(LOCK, KEY);
      rd(LOCK, 32'h0, "R2 unlocked");

      // R4 claim
      wr(ca(0, 'h00), 32'h1);
      rd(ca(0, 'h00), 32'h1, "R4 owner");
      rd(ca(0, 'h10), 32'h20, "R4 mode");
      wr(ca(0, 'h00), 32'h4);
      rd(ca(0, 'h00), 32'h1, "R4 second claim");

      // config + R9 message
      wr(ca(0, 'h04), 32'h8);
      wr(ca(0, 'h14), ~32'h8);
      wr(ca(0, 'h10), 32'h1);
      for (int w = 0; w < 8; w++) wr(ca(0, 'h20 + 4 * w), 32'h1111_1111 * w + 32'h5);
      rd(ca(0, 'h3C), 32'h1111_1111 * 7 + 32'h5, "R9 word7");
      rd(ca(0, 'h20), 32'h5, "R9 word0");

      // R5 send
      wr(ca(0, 'h1C), 32'h2);
      rd(ca(0, 'h10), 32'h21, "R5 bad send");
      wr(ca(0, 'h1C), 32'h1);
      chk("R5 irq_dst", irq_dst, 32'h8);
      chk("R6 irq_src before", irq_src, 32'h0);
      @(negedge clk);
      chk("R6 irq_src", irq_src, 32'h1);
      rd(ca(0, 'h10), 32'h81, "R6 mode");

      // R8 target status and clear
      rd(ca(0, 'h0C), 32'h8, "R8 tstat");
      wr(ca(0, 'h08), 32'h8);
      chk("R8 irq_dst cleared", irq_dst, 32'h0);
      rd(ca(0, 'h0C), 32'h0, "R8 tstat cleared");

      // R7 ack clear
      wr(ca(0, 'h18), 32'h1);
      chk("R7 irq_src", irq_src, 32'h0);
      rd(ca(0, 'h10), 32'h21, "R7 mode");

      // R8 manual acknowledge
      wr(ca(1, 'h00), 32'h2);
      wr(ca(1, 'h04), 32'h10);
      wr(ca(1, 'h14), 32'h0);
      wr(ca(1, 'h1C), 32'h2);
      @(negedge clk);
      rd(ca(1, 'h10), 32'h0, "R8 manual in flight");
      chk("R8 manual no ack", irq_src & 32'h2, 32'h0);
      wr(ca(1, 'h08), 32'h10);
      chk("R8 manual ack", irq_src & 32'h2, 32'h2);
      rd(ca(1, 'h10), 32'h80, "R8 manual mode");

      // R12 coincident raise and clear on a shared vector
      wr(ca(2, 'h00), 32'h4);
      wr(ca(3, 'h00), 32'h4);
      wr(ca(2, 'h10), 32'h1);
      wr(ca(3, 'h10), 32'h1);
      wr(ca(3, 'h1C), 32'h4);
      @(negedge clk);
      chk("R12 first ack", irq_src & 32'h4, 32'h4);
      wr(ca(2, 'h1C), 32'h4);
      wr(ca(3, 'h18), 32'h4);
      chk("R12 shared vector", irq_src & 32'h4, 32'h4);
      rd(ca(3, 'h10), 32'h21, "R12 ch3 owned");
      rd(ca(2, 'h10), 32'h81, "R12 ch2 acked");

      // R10 release
      wr(ca(0, 'h00), 32'h0);
      rd(ca(0, 'h10), 32'h11, "R10 mode");
      rd(ca(0, 'h00), 32'h0, "R10 owner");

      // R11 unmapped
      rd(12'h900, 32'h0, "R11 unmapped");

      // R2 relock, R3 ignored
      wr(LOCK, 32'h1234);
      rd(LOCK, 32'h1, "R2 relocked");
      wr(ca(0, 'h00), 32'h8);
      rd(ca(0, 'h10), 32'h11, "R3 relocked mode");

      // mixed random run checked by the model
      wr(LOCK, KEY);
      for (int n = 0; n < 4000; n++) begin
         int c;
         int o;
         int k;
         logic [31:0] v;
         c = $urandom_range(0, 3);
         o = 4 * $urandom_range(0, 15);
         k = $urandom_range(0, 4);
         v = (k == 4) ? 32'h0 : (32'h1 << k);
         if ($urandom_range(0, 99) < 2) begin
            wr(LOCK, ($urandom_range(0, 3) == 0) ? 32'h0 : KEY);
         end else if ($urandom_range(0, 2) == 0) begin
            bus_req = 1'b1; bus_we = 1'b0; bus_addr = ca(c, o);
            @(negedge clk);
            bus_req = 1'b0;
         end else begin
            if (o == 'h10 || o == 'h14) v = {31'h0, v[0]} | (($urandom_range(0, 1) == 1) ? 32'h0 : v);
            wr(ca(c, o), v);
         end
      end
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule